// File: doc/BRIEF.md
# Edwards Curve Point Add/Double Micro-Op Sequencer

This block steers a shared field datapath through one twisted-Edwards point operation in extended projective coordinates (X, Y, Z, T). It does no arithmetic itself. On a start pulse it samples an operation select and walks a fixed schedule of steps. Each step issues up to one modular multiplication and up to three modular additions or subtractions at the same time. Every micro-op names its operands and destination by index into a shared register file of coordinates and named temporaries. The schedule interleaves the two kinds of operation so that the single pipelined multiplier gets a new product in every step that has one.

The datapath reports which register slots hold settled values through a valid vector. It also reports whether the multiplier can accept an operand pair. A step issues only when all of its operands are settled and the multiplier, if the step needs it, is ready. Until then the sequencer holds on that step, so any multiplier or adder latency is tolerated. The last step of each operation issues nothing and waits for the final product to land.

`done` then pulses for one cycle. The result is left in the second point's coordinate slots: Q = 2P for doubling, Q = P + Q for addition. The curve constant d sits in a fixed slot that micro-ops read but never write.

Top module: `edw_pt_seq`

## Requirements
- R1: While `rst` is high, and afterwards until `start` is seen, `mul_vld`, every bit of `alu_vld` and `done` are low. A `start` held high during reset starts nothing.
- R2: With `op_dbl`=1 sampled at start, the operation takes 9 steps. Multiplications are issued with destinations in this order: A, t1, B, t2, Y2, X2, Z2, T2. They compute A=X1², t1=Z1², B=Y1², t2=t2², Y2=G·H, X2=E·F, Z2=F·G, T2=E·H. The slots then hold 2P, where C=2t1, H=A+B, G=A−B, E=H−(X1+Y1)² and F=C+G.
- R3: With `op_dbl`=0 sampled at start, the operation takes 12 steps. Steps 1 and 2 issue no multiplication. Multiplication destinations follow in this order: A, B, t1, D, C, T2, Y2, X2, Z2. They compute A=A1·A2, B=B1·B2, t1=t1·d, D=t2·Z2, C=t1·T2, T2=E·H, Y2=G·H, X2=E·F, Z2=F·G. The slots then hold P+Q.
- R4: Additions and subtractions are grouped with the multiplication issued in the same cycle. For doubling: t2=X1+Y1 goes with B; C=t1+t1, H=A+B and G=A−B go with t2²; E=H−t2 and F=C+G go with Y2. For addition: A1=Y1−X1 and B1=Y1+X1 go in step 1, and A2=Y2−X2 and B2=Y2+X2 go in step 2, each with no product. t1=T1+T1 goes with B; t2=Z1+Z1 goes with the product by d; E=B−A and H=B+A go with C; F=D−C and G=D+C go with T2.
- R5: No micro-op is issued while any of its source slots has `reg_valid` low. No multiplication is issued while `mul_rdy` is low.
- R6: A step that cannot issue holds the step counter. The issue order and the results are the same for any datapath latency and any `mul_rdy` pattern.
- R7: The final step issues nothing and waits until the last product's slot is valid (T2 for doubling, Z2 for addition). `done` is high for exactly one cycle, the cycle after that step completes. At that point no operation is outstanding.
- R8: Slot 22 holds the curve constant d. It is the operand of the addition's t1·d product and is never a destination.
- R9: `start` and `op_dbl` are ignored from the cycle after an accepted start until the cycle after `done`.
- R10: Slot encoding: 0–3 hold X1, Y1, Z1, T1 (point P); 4–7 hold X2, Y2, Z2, T2 (point Q and the result); 8–15 hold A, B, C, D, E, F, G, H; 16 and 17 hold t1 and t2; 18–21 hold A1, B1, A2, B2; 22 holds d. Lane field i of a flattened index bus is bits [5i+4:5i]. `alu_sub`=1 means source a minus source b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| op_dbl | input | 1 | 1 = doubling, 0 = addition, sampled with start |
| mul_rdy | input | 1 | Multiplier can accept an operand pair this cycle |
| reg_valid | input | 23 | Per-slot settled flag from the datapath |
| mul_vld | output | 1 | Multiplication issued this cycle |
| mul_src_a | output | 5 | Multiplier operand a slot |
| mul_src_b | output | 5 | Multiplier operand b slot |
| mul_dst | output | 5 | Product destination slot |
| alu_vld | output | 3 | Per-lane add/sub issued this cycle |
| alu_sub | output | 3 | Per-lane subtract select |
| alu_src_a | output | 15 | Per-lane operand a slots, flattened |
| alu_src_b | output | 15 | Per-lane operand b slots, flattened |
| alu_dst | output | 15 | Per-lane destination slots, flattened |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default slot count, index width and three add lanes. It surrounds the block with a behavioural field unit over the prime 13 whose multiplier latency sweeps 1 to 5 cycles, with and without pseudo-random multiplier backpressure. Because the field is this small, doubling can be run for every (X1, Y1) pair, and addition for every value of d. Each result is compared with the closed-form formulas evaluated in the bench. The model also logs the order of products, the pairing of add lanes with products, any read of an unsettled slot and any outstanding work at `done`.

// File: rtl/edw_seq_pkg.sv
package edw_seq_pkg;

    localparam int IDX_W     = 5;
    localparam int NREG      = 23;
    localparam int N_LANE    = 3;
    localparam int DBL_STEPS = 9;
    localparam int ADD_STEPS = 12;
    localparam int MAX_STEPS = (DBL_STEPS > ADD_STEPS) ? DBL_STEPS : ADD_STEPS;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    typedef logic [IDX_W-1:0]  ridx_t;
    typedef logic [STEP_W-1:0] step_idx_t;

    // register slot map
    localparam ridx_t R_X1 = ridx_t'(0);
    localparam ridx_t R_Y1 = ridx_t'(1);
    localparam ridx_t R_Z1 = ridx_t'(2);
    localparam ridx_t R_T1 = ridx_t'(3);
    localparam ridx_t R_X2 = ridx_t'(4);
    localparam ridx_t R_Y2 = ridx_t'(5);
    localparam ridx_t R_Z2 = ridx_t'(6);
    localparam ridx_t R_T2 = ridx_t'(7);
    localparam ridx_t R_A  = ridx_t'(8);
    localparam ridx_t R_B  = ridx_t'(9);
    localparam ridx_t R_C  = ridx_t'(10);
    localparam ridx_t R_D  = ridx_t'(11);
    localparam ridx_t R_E  = ridx_t'(12);
    localparam ridx_t R_F  = ridx_t'(13);
    localparam ridx_t R_G  = ridx_t'(14);
    localparam ridx_t R_H  = ridx_t'(15);
    localparam ridx_t R_U1 = ridx_t'(16);
    localparam ridx_t R_U2 = ridx_t'(17);
    localparam ridx_t R_A1 = ridx_t'(18);
    localparam ridx_t R_B1 = ridx_t'(19);
    localparam ridx_t R_A2 = ridx_t'(20);
    localparam ridx_t R_B2 = ridx_t'(21);
    localparam ridx_t R_KD = ridx_t'(22);   // curve constant, read-only

    typedef struct packed {
        logic  en;
        ridx_t a;
        ridx_t b;
        ridx_t d;
    } mul_op_t;

    typedef struct packed {
        logic  en;
        logic  sub;
        ridx_t a;
        ridx_t b;
        ridx_t d;
    } alu_op_t;

    typedef struct packed {
        mul_op_t                  mul;
        alu_op_t [N_LANE-1:0]     alu;
        logic                     wt;     // pure wait step
        ridx_t                    wsrc;   // slot waited on
        logic                     last;
    } step_t;

    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} seq_state_e;

    function automatic mul_op_t mk_mul(input ridx_t a, input ridx_t b, input ridx_t d);
        mul_op_t m;
        m.en = 1'b1; m.a = a; m.b = b; m.d = d;
        return m;
    endfunction

    function automatic alu_op_t mk_alu(input logic sub, input ridx_t a, input ridx_t b,
                                       input ridx_t d);
        alu_op_t o;
        o.en = 1'b1; o.sub = sub; o.a = a; o.b = b; o.d = d;
        return o;
    endfunction

    function automatic step_t mk_wait(input ridx_t src);
        step_t s;
        s      = '0;
        s.wt   = 1'b1;
        s.wsrc = src;
        s.last = 1'b1;
        return s;
    endfunction

    // doubling schedule, Q = 2P
    function automatic step_t dbl_step(input step_idx_t k);
        step_t s;
        s = '0;
        case (int'(k))
            0: s.mul = mk_mul(R_X1, R_X1, R_A);
            1: s.mul = mk_mul(R_Z1, R_Z1, R_U1);
            2: begin
                s.mul    = mk_mul(R_Y1, R_Y1, R_B);
                s.alu[0] = mk_alu(1'b0, R_X1, R_Y1, R_U2);
            end
            3: begin
                s.mul    = mk_mul(R_U2, R_U2, R_U2);
                s.alu[0] = mk_alu(1'b0, R_U1, R_U1, R_C);
                s.alu[1] = mk_alu(1'b0, R_A, R_B, R_H);
                s.alu[2] = mk_alu(1'b1, R_A, R_B, R_G);
            end
            4: begin
                s.mul    = mk_mul(R_G, R_H, R_Y2);
                s.alu[0] = mk_alu(1'b1, R_H, R_U2, R_E);
                s.alu[1] = mk_alu(1'b0, R_C, R_G, R_F);
            end
            5: s.mul = mk_mul(R_E, R_F, R_X2);
            6: s.mul = mk_mul(R_F, R_G, R_Z2);
            7: s.mul = mk_mul(R_E, R_H, R_T2);
            8: s = mk_wait(R_T2);
            default: s = '0;
        endcase
        return s;
    endfunction

    // addition schedule, Q = P + Q
    function automatic step_t add_step(input step_idx_t k);
        step_t s;
        s = '0;
        case (int'(k))
            0: begin
                s.alu[0] = mk_alu(1'b1, R_Y1, R_X1, R_A1);
                s.alu[1] = mk_alu(1'b0, R_Y1, R_X1, R_B1);
            end
            1: begin
                s.alu[0] = mk_alu(1'b1, R_Y2, R_X2, R_A2);
                s.alu[1] = mk_alu(1'b0, R_Y2, R_X2, R_B2);
            end
            2: s.mul = mk_mul(R_A1, R_A2, R_A);
            3: begin
                s.mul    = mk_mul(R_B1, R_B2, R_B);
                s.alu[0] = mk_alu(1'b0, R_T1, R_T1, R_U1);
            end
            4: begin
                s.mul    = mk_mul(R_U1, R_KD, R_U1);
                s.alu[0] = mk_alu(1'b0, R_Z1, R_Z1, R_U2);
            end
            5: s.mul = mk_mul(R_U2, R_Z2, R_D);
            6: begin
                s.mul    = mk_mul(R_U1, R_T2, R_C);
                s.alu[0] = mk_alu(1'b1, R_B, R_A, R_E);
                s.alu[1] = mk_alu(1'b0, R_B, R_A, R_H);
            end
            7: begin
                s.mul    = mk_mul(R_E, R_H, R_T2);
                s.alu[0] = mk_alu(1'b1, R_D, R_C, R_F);
                s.alu[1] = mk_alu(1'b0, R_D, R_C, R_G);
            end
            8:  s.mul = mk_mul(R_G, R_H, R_Y2);
            9:  s.mul = mk_mul(R_E, R_F, R_X2);
            10: s.mul = mk_mul(R_F, R_G, R_Z2);
            11: s = mk_wait(R_Z2);
            default: s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/edw_step_table.sv
module edw_step_table
    import edw_seq_pkg::*;
(
    input  logic      op_dbl,
    input  step_idx_t step,
    output step_t     ent
);
    step_t dbl_ent;
    step_t add_ent;

    always_comb begin
        dbl_ent = dbl_step(step);
        add_ent = add_step(step);
        ent     = op_dbl ? dbl_ent : add_ent;
    end
endmodule

// File: rtl/edw_opnd_gate.sv
module edw_opnd_gate
    import edw_seq_pkg::*;
(
    input  step_t            ent,
    input  logic [NREG-1:0]  reg_valid,
    input  logic             mul_rdy,
    output logic             go
);
    logic [N_LANE-1:0] lane_ok;
    logic              mul_ok;
    logic              wait_ok;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign lane_ok[g] = !ent.alu[g].en
                          || (reg_valid[ent.alu[g].a] && reg_valid[ent.alu[g].b]);
    end

    assign mul_ok  = !ent.mul.en
                   || (mul_rdy && reg_valid[ent.mul.a] && reg_valid[ent.mul.b]);
    assign wait_ok = !ent.wt || reg_valid[ent.wsrc];
    assign go      = (&lane_ok) && mul_ok && wait_ok;
endmodule

// File: rtl/edw_step_ctrl.sv
module edw_step_ctrl
    import edw_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      op_dbl,
    input  logic      go,
    input  logic      last,
    output logic      running,
    output logic      done,
    output logic      op_q,
    output step_idx_t step
);
    seq_state_e st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            step <= '0;
            op_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    st   <= S_RUN;
                    step <= '0;
                    op_q <= op_dbl;
                end
                S_RUN: if (go) begin
                    if (last) st <= S_FIN;
                    else      step <= step + 1'b1;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign running = (st == S_RUN);
    assign done    = (st == S_FIN);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_wait_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(running && go && last));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (running && !go) |=> (running && $stable(step)));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (running || done) |=> $stable(op_q));
endmodule

// File: rtl/edw_pt_seq.sv
module edw_pt_seq
    import edw_seq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     op_dbl,
    input  logic                     mul_rdy,
    input  logic [NREG-1:0]          reg_valid,
    output logic                     mul_vld,
    output logic [IDX_W-1:0]         mul_src_a,
    output logic [IDX_W-1:0]         mul_src_b,
    output logic [IDX_W-1:0]         mul_dst,
    output logic [N_LANE-1:0]        alu_vld,
    output logic [N_LANE-1:0]        alu_sub,
    output logic [N_LANE*IDX_W-1:0]  alu_src_a,
    output logic [N_LANE*IDX_W-1:0]  alu_src_b,
    output logic [N_LANE*IDX_W-1:0]  alu_dst,
    output logic                     done
);
    step_t     ent;
    step_idx_t step;
    logic      op_q;
    logic      running;
    logic      go;
    logic      issue;

    edw_step_table u_table (
        .op_dbl (op_q),
        .step   (step),
        .ent    (ent)
    );

    edw_opnd_gate u_gate (
        .ent       (ent),
        .reg_valid (reg_valid),
        .mul_rdy   (mul_rdy),
        .go        (go)
    );

    edw_step_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .op_dbl  (op_dbl),
        .go      (go),
        .last    (ent.last),
        .running (running),
        .done    (done),
        .op_q    (op_q),
        .step    (step)
    );

    assign issue     = running && go;
    assign mul_vld   = issue && ent.mul.en;
    assign mul_src_a = ent.mul.a;
    assign mul_src_b = ent.mul.b;
    assign mul_dst   = ent.mul.d;

    for (genvar g = 0; g < N_LANE; g++) begin : g_out
        assign alu_vld[g]                    = issue && ent.alu[g].en;
        assign alu_sub[g]                    = ent.alu[g].sub;
        assign alu_src_a[g*IDX_W +: IDX_W]   = ent.alu[g].a;
        assign alu_src_b[g*IDX_W +: IDX_W]   = ent.alu[g].b;
        assign alu_dst[g*IDX_W +: IDX_W]     = ent.alu[g].d;

        assert_alu_kd_ro_R8: assert property (@(posedge clk) disable iff (rst)
            alu_vld[g] |-> (alu_dst[g*IDX_W +: IDX_W] != R_KD));

        assert_alu_opnd_R5: assert property (@(posedge clk) disable iff (rst)
            alu_vld[g] |-> (reg_valid[alu_src_a[g*IDX_W +: IDX_W]]
                            && reg_valid[alu_src_b[g*IDX_W +: IDX_W]]));
    end

    assert_mul_rdy_R5: assert property (@(posedge clk) disable iff (rst)
        mul_vld |-> mul_rdy);

    assert_mul_opnd_R5: assert property (@(posedge clk) disable iff (rst)
        mul_vld |-> (reg_valid[mul_src_a] && reg_valid[mul_src_b]));

    assert_mul_kd_ro_R8: assert property (@(posedge clk) disable iff (rst)
        mul_vld |-> (mul_dst != R_KD));

    assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(running) && !running |-> (!mul_vld && alu_vld == '0));
endmodule

// File: tb/edw_pt_seq_tb.sv
module edw_pt_seq_tb;
    import edw_seq_pkg::*;

    localparam int P     = 13;
    localparam int NSLOT = 16;
    localparam int NONE  = 31;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic start = 1'b0;
    logic op_dbl = 1'b0;
    logic mul_rdy = 1'b1;
    logic [NREG-1:0] rv = '1;

    logic                    mul_vld;
    logic [IDX_W-1:0]        mul_src_a, mul_src_b, mul_dst;
    logic [N_LANE-1:0]       alu_vld, alu_sub;
    logic [N_LANE*IDX_W-1:0] alu_src_a, alu_src_b, alu_dst;
    logic                    done;

    edw_pt_seq u_dut (
        .clk(clk), .rst(rst), .start(start), .op_dbl(op_dbl), .mul_rdy(mul_rdy),
        .reg_valid(rv), .mul_vld(mul_vld), .mul_src_a(mul_src_a),
        .mul_src_b(mul_src_b), .mul_dst(mul_dst), .alu_vld(alu_vld),
        .alu_sub(alu_sub), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
        .alu_dst(alu_dst), .done(done)
    );

    int checks = 0;
    int fails  = 0;

    // behavioural field unit over GF(P)
    int rf[NREG];
    int in_val[NREG];
    logic ld = 1'b0;
    logic [NSLOT-1:0] sb = '0;
    int sc[NSLOT];
    int sd[NSLOT];
    int sv[NSLOT];
    int lat = 1;
    int rdy_mode = 0;
    logic [7:0] lfsr = 8'h5a;

    int mlog[16];
    int mcnt = 0;
    int pair[32];
    int acnt = 0;
    int viol = 0;
    int done_cnt = 0;
    logic [NREG-1:0]  done_rv = '0;
    logic [NSLOT-1:0] done_sb = '0;

    function automatic int md(input int v);
        return ((v % P) + P) % P;
    endfunction

    function automatic int pick(input logic [NSLOT-1:0] u);
        for (int i = 0; i < NSLOT; i++) if (!u[i]) return i;
        return 0;
    endfunction

    always @(negedge clk) begin
        lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mul_rdy <= (rdy_mode == 0) ? 1'b1 : (lfsr[0] | lfsr[2]);
    end

    always @(posedge clk) begin
        logic [NSLOT-1:0] used;
        int s, a, b, d;
        used = sb;
        if (ld) begin
            for (int i = 0; i < NREG; i++) rf[i] <= in_val[i];
            rv <= '1;
            sb <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (sb[i]) begin
                    if (sc[i] <= 1) begin
                        rf[sd[i]] <= sv[i];
                        rv[sd[i]] <= 1'b1;
                        sb[i]     <= 1'b0;
                    end else begin
                        sc[i] <= sc[i] - 1;
                    end
                end
            end
            if (done) begin
                done_cnt++;
                done_rv = rv;
                done_sb = sb;
            end
            if (mul_vld) begin
                a = int'(mul_src_a); b = int'(mul_src_b); d = int'(mul_dst);
                if (!rv[a] || !rv[b] || !mul_rdy) viol++;
                s = pick(used); used[s] = 1'b1;
                sb[s] <= 1'b1; sc[s] <= lat; sd[s] <= d; sv[s] <= md(rf[a] * rf[b]);
                rv[d] <= 1'b0;
                if (mcnt < 16) mlog[mcnt] = d;
                mcnt++;
            end
            for (int g = 0; g < N_LANE; g++) begin
                if (alu_vld[g]) begin
                    a = int'(alu_src_a[g*IDX_W +: IDX_W]);
                    b = int'(alu_src_b[g*IDX_W +: IDX_W]);
                    d = int'(alu_dst[g*IDX_W +: IDX_W]);
                    if (!rv[a] || !rv[b]) viol++;
                    s = pick(used); used[s] = 1'b1;
                    sb[s] <= 1'b1; sc[s] <= 1; sd[s] <= d;
                    sv[s] <= alu_sub[g] ? md(rf[a] - rf[b]) : md(rf[a] + rf[b]);
                    rv[d] <= 1'b0;
                    pair[d] = mul_vld ? int'(mul_dst) : NONE;
                    acnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_mul(input bit op, input int i);
        int dl[8] = '{8, 16, 9, 17, 5, 4, 6, 7};
        int al[9] = '{8, 9, 16, 11, 10, 7, 5, 4, 6};
        return op ? dl[i] : al[i];
    endfunction

    function automatic int exp_pair(input bit op, input int d);
        if (op) begin
            case (d)
                17: return 9;
                10, 15, 14: return 17;
                12, 13: return 5;
                default: return -1;
            endcase
        end
        case (d)
            18, 19, 20, 21: return NONE;
            16: return 9;
            17: return 16;
            12, 15: return 10;
            13, 14: return 7;
            default: return -1;
        endcase
    endfunction

    task automatic run_op(input bit op, input int x1, input int y1, input int z1,
                          input int t1, input int x2, input int y2, input int z2,
                          input int t2, input int dk, input bit inj);
        int ea, eb, ec, ed, ee, ef, eg, eh;
        int ex, ey, ez, et;
        int d0, cyc, nm, na, bad_ord, bad_pair;
        string tg;
        if (op) begin
            ea = md(x1 * x1); eb = md(y1 * y1); ec = md(2 * z1 * z1);
            eh = md(ea + eb); ee = md(eh - md((x1 + y1) * (x1 + y1)));
            eg = md(ea - eb); ef = md(ec + eg);
            nm = 8; na = 6; tg = "R2";
        end else begin
            ea = md(md(y1 - x1) * md(y2 - x2)); eb = md(md(y1 + x1) * md(y2 + x2));
            ec = md(md(2 * t1 * dk) * t2); ed = md(2 * z1 * z2);
            ee = md(eb - ea); ef = md(ed - ec); eg = md(ed + ec); eh = md(eb + ea);
            nm = 9; na = 10; tg = "R3";
        end
        ex = md(ee * ef); ey = md(eg * eh); ez = md(ef * eg); et = md(ee * eh);

        @(negedge clk);
        for (int i = 0; i < NREG; i++) in_val[i] = (i * 5 + 3) % P;
        in_val[0] = x1; in_val[1] = y1; in_val[2] = z1; in_val[3] = t1;
        in_val[4] = x2; in_val[5] = y2; in_val[6] = z2; in_val[7] = t2;
        in_val[22] = dk;
        for (int i = 0; i < 32; i++) pair[i] = -1;
        mcnt = 0; acnt = 0; viol = 0;
        ld = 1'b1;
        @(negedge clk);
        ld = 1'b0;
        d0 = done_cnt;
        start = 1'b1; op_dbl = op;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done_cnt == d0 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (inj && (cyc == 3 || cyc == 9)) begin
                start = 1'b1; op_dbl = !op;
            end else begin
                start = 1'b0; op_dbl = op;
            end
        end
        start = 1'b0;
        chk(cyc < 400, {tg, " hang"}, cyc, 0);
        repeat (4) @(negedge clk);

        chk(rf[4] == ex && rf[5] == ey && rf[6] == ez && rf[7] == et,
            {tg, "/R10 result X2"}, rf[4], ex);
        chk(rf[7] == et && rf[6] == ez, {tg, " result T2"}, rf[7], et);
        bad_ord = 0;
        for (int i = 0; i < nm; i++) if (i >= mcnt || mlog[i] != exp_mul(op, i)) bad_ord++;
        chk(mcnt == nm && bad_ord == 0, {tg, "/R6 product order"}, mcnt, nm);
        bad_pair = 0;
        for (int i = 0; i < 32; i++) if (pair[i] != exp_pair(op, i)) bad_pair++;
        chk(acnt == na && bad_pair == 0, "R4 lane grouping", bad_pair, 0);
        chk(viol == 0, "R5 pending operand or ready", viol, 0);
        chk(done_rv == '1 && done_sb == '0, "R7 outstanding at done", int'(done_sb), 0);
        chk(done_cnt - d0 == 1, inj ? "R9 extra run" : "R7 done count", done_cnt - d0, 1);
        chk(rf[22] == dk, "R8 constant slot", rf[22], dk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b1; op_dbl = 1'b1;
        repeat (3) @(negedge clk);
        chk(!mul_vld && alu_vld == '0 && !done, "R1 in reset", int'(alu_vld), 0);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!mul_vld && alu_vld == '0 && !done, "R1 idle after reset", int'(mul_vld), 0);
        end

        // latency / backpressure sweep, both operations
        for (int op = 0; op < 2; op++)
            for (int l = 1; l <= 5; l++)
                for (int rm = 0; rm < 2; rm++)
                    for (int k = 0; k < 6; k++) begin
                        lat = l; rdy_mode = rm;
                        run_op(op[0], (3*k+1) % P, (5*k+2) % P, (k+4) % P, (7*k+3) % P,
                               (2*k+5) % P, (11*k+6) % P, (4*k+1) % P, (9*k+8) % P,
                               (k+2) % P, k == 2);
                    end

        // doubling over every (X1, Y1)
        lat = 3; rdy_mode = 1;
        for (int x = 0; x < P; x++)
            for (int y = 0; y < P; y++)
                run_op(1'b1, x, y, (x + 2*y + 1) % P, 0, 0, 0, 0, 0, 5, 1'b0);

        // addition over every d
        lat = 2; rdy_mode = 0;
        for (int dv = 0; dv < P; dv++)
            run_op(1'b0, 4, 7, 2, 9, 11, 3, 6, 10, dv, dv == 6);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule